// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up-counter built from 4-bit slices that all change state on the same rising clock edge. Each slice can be cleared to zero, preset from a parallel data word, counted up by one or held. Two count enables control counting. A parallel enable is shared by every slice. A trickle enable is fed from slice to slice, so the carry of one stage decides whether the next stage advances. Because the carry-out of the last stage is combinational, further counters can be chained behind it with no extra gating.

Clear has the highest priority, then load, then count, and hold comes last. A shorter count cycle is made outside the block: an active-low decode of the chosen last count is fed back into the clear input, so the count returns to zero on the edge that follows that value. A synchronous active-high reset also forces the count to zero.

Top module: `casc_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes zero on that edge, whatever the levels on every other input.
- R2: With `rst` low, `clr_n` low at a rising edge makes the whole count zero, whatever the levels on `load_n`, `en_par` and `en_trk`.
- R3: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value of `din`, bit 0 being the least significant, whatever the enable levels.
- R4: With `clr_n` and `load_n` high, the count increases by one at a rising edge only when `en_par` and `en_trk` are both high; otherwise it keeps its value.
- R5: The slices act as one wide binary counter: a carry crosses every slice boundary, and the all-ones count wraps to zero when it increments.
- R6: `carry_out` is high exactly when `en_trk` is high and every bit of `q` is one; `en_par` has no effect on it.
- R7: A change on any control or data input between clock edges leaves `q` unchanged until the next rising edge.
- R8: Driving `clr_n` low while `q` equals a chosen value N, with both enables high, makes the count run 0, 1, ..., N and then start again at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Active-low synchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, shared by all slices |
| en_trk | input | 1 | Trickle count enable into the lowest slice; also gates the carry-out |
| din | input | SLICES*SLICE_W | Preset data, bit 0 least significant |
| q | output | SLICES*SLICE_W | Concatenated count value |
| carry_out | output | 1 | Carry-out of the last slice |

## Verification
Every 8-bit value of a two-slice chain is first preset and then put through all sixteen combinations of clear, load and the two enables. This sweep separates the priority order, the hold cases where only one enable is high, the carry across the slice boundary and the wrap from 255. The carry-out is sampled before each edge for every combination, so a carry that wrongly depends on the parallel enable shows up. Changes to the inputs in mid-cycle are checked against an unchanged count. A decode-and-clear loop must then repeat 0 to 9, and a reset with load active must still give zero.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Operation chosen for the coming clock edge, by priority.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic en_par,
  output op_e  op
);
  // Clear over load over count; the trickle enable is applied per slice.
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (en_par)  op = OP_COUNT;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  op_e          op,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        OP_CLEAR: q <= '0;
        OP_LOAD:  q <= din;
        OP_COUNT: if (en_trk) q <= q + ONE;
        default:  q <= q;
      endcase
    end
  end

  // Look-ahead carry: this slice is at its top value and may pass a count on.
  assign carry = en_trk & (&q);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLEAR) |=> (q == '0));

  p_load_data_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q == $past(din)));

  p_hold_value_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || (op == OP_COUNT && !en_trk)) |=> $stable(q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COUNT && en_trk) |=> (q == $past(q) + ONE));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int SLICES  = 2,
  parameter int SLICE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       en_par,
  input  logic                       en_trk,
  input  logic [SLICES*SLICE_W-1:0]  din,
  output logic [SLICES*SLICE_W-1:0]  q,
  output logic                       carry_out
);
  localparam int TOTAL_W = SLICES * SLICE_W;

  op_e         op;
  logic [SLICES:0] trk;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .op     (op)
  );

  assign trk[0] = en_trk;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .en_trk (trk[i]),
      .din    (din[i*SLICE_W +: SLICE_W]),
      .q      (q[i*SLICE_W +: SLICE_W]),
      .carry  (trk[i+1])
    );
  end

  assign carry_out = trk[SLICES];

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (q == '0));

  p_carry_terminal_r6: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (en_trk && (q == {TOTAL_W{1'b1}})));

  p_terminal_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (en_trk && (q == {TOTAL_W{1'b1}})) |-> carry_out);

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_par && en_trk && (q == {TOTAL_W{1'b1}})) |=> (q == '0));
endmodule

// File: tb/casc_counter_tb.sv
`timescale 1ns/1ps
module casc_counter_tb;
  localparam int SLICES  = 2;
  localparam int SLICE_W = 4;
  localparam int TW      = SLICES * SLICE_W;
  localparam int MAXV    = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_n = 1'b1;
  logic          load_n = 1'b1;
  logic          en_par = 1'b0;
  logic          en_trk = 1'b0;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] q;
  logic          carry_out;

  int errors = 0;
  int checks = 0;
  int exp_q  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  casc_counter #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
    .en_par(en_par), .en_trk(en_trk), .din(din),
    .q(q), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_next(int cur, bit c, bit l, bit p, bit t, int d);
    if (!c) return 0;
    if (!l) return d;
    if (p && t) return (cur + 1) & MAXV;
    return cur;
  endfunction

  // At a falling edge: check the last edge's result, drive new inputs,
  // confirm the count has not moved and the carry matches.
  task automatic step(input bit c, input bit l, input bit p, input bit t,
                      input int d, input string req);
    @(negedge clk);
    chk(int'(q) == exp_q, req, int'(q), exp_q);
    clr_n = c; load_n = l; en_par = p; en_trk = t; din = TW'(d);
    #1;
    chk(int'(q) == exp_q, "R7", int'(q), exp_q);
    chk(carry_out == (t && exp_q == MAXV), "R6", int'(carry_out),
        int'(t && exp_q == MAXV));
    exp_q = model_next(exp_q, c, l, p, t, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q == '0, "R1", int'(q), 0);
    rst = 1'b0;
    exp_q = 0;

    // Exhaustive sweep: every start value through every control combination.
    for (int s = 0; s <= MAXV; s++) begin
      for (int cmb = 0; cmb < 16; cmb++) begin
        bit c = cmb[3];
        bit l = cmb[2];
        bit p = cmb[1];
        bit t = cmb[0];
        string req;
        step(1'b1, 1'b0, 1'b0, 1'b0, s, "R3");
        if (!c)           req = "R2";
        else if (!l)      req = "R3";
        else if (p && t)  req = (s == MAXV || (s & 15) == 15) ? "R5" : "R4";
        else              req = "R4";
        step(c, l, p, t, s ^ 8'hA5, req);
      end
    end
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, "R4");

    // R5: long run across the slice boundary and through the wrap.
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hF0, "R4");
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R5");

    // R8: modulo-10 by decoding 9 into clear.
    step(1'b0, 1'b1, 1'b1, 1'b1, 0, "R5");
    for (int k = 0; k < 35; k++) begin
      @(negedge clk);
      chk(int'(q) == (k % 10), "R8", int'(q), k % 10);
      clr_n = (q != TW'(9));
      load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    end

    // R1: reset wins over an active load.
    @(negedge clk);
    rst = 1'b1; clr_n = 1'b1; load_n = 1'b0; din = TW'(8'h5A);
    @(negedge clk);
    chk(q == '0, "R1", int'(q), 0);
    rst = 1'b0; load_n = 1'b1; en_par = 1'b0;
    @(negedge clk);
    chk(q == '0, "R1", int'(q), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule